// File: doc/BRIEF.md
# Nibble Execution Unit with Row/Column Data Memory

This block is the data path of a small 4-bit controller core. It holds sixteen 4-bit working registers and a data memory addressed by a row field and a column field. Each cycle it can accept one decoded operation. The operation names a row, a primary column, a second column, a register index and a 4-bit immediate. The immediate also serves as a bit mask.

The unit covers several groups of operations. Logic operations combine a register with memory, or combine memory with an immediate. There is a right rotate through the carry. There are loads, stores and immediate writes. Moves stay inside one row and can take their column either from the instruction or from the contents of a register. Mask tests raise a skip request for the sequencer.

Every accepted operation shows its result one clock later on registered outputs. These outputs say what was written and whether the target was memory or a register. The same stage carries the carry flag and the skip request. Instruction fetch and port I/O live elsewhere.

Top module: `nib_exec`

## Requirements
- R1: Register logic forms (code 1 = AND, 3 = OR, 5 = XOR) set reg[reg_sel] to reg[reg_sel] combined with mem[row][col]. One clock after the operation is presented, wb_valid=1, wb_to_mem=0 and wb_data holds the new value.
- R2: Immediate logic forms (code 2 = AND, 4 = OR, 6 = XOR) set mem[row][col] to mem[row][col] combined with imm. One clock later wb_valid=1, wb_to_mem=1 and wb_data holds the new value.
- R3: The right rotate (code 7) sets reg[reg_sel] to {carry, reg[reg_sel][3:1]}. Carry takes the old bit 0. One clock later the outputs report a register write and show the new carry.
- R4: Only code 7 changes the carry. Every other operation, and every idle cycle, leaves it unchanged.
- R5: Code 8 loads mem[row][col] into reg[reg_sel]. Code 9 stores reg[reg_sel] into mem[row][col]. Code 13 writes imm into mem[row][col].
- R6: Code 12 copies mem[row][col_src] into mem[row][col]. No other row is touched.
- R7: Code 10 writes mem[row][col] into mem[row][reg[reg_sel]]. Code 11 writes mem[row][reg[reg_sel]] into mem[row][col]. In both cases the register contents pick the column.
- R8: Code 14 requests a skip when every bit selected by imm is 1 in mem[row][col]. Code 15 requests a skip when every selected bit is 0. Skip is high for exactly the one cycle after the test. Tests write nothing, so wb_valid=0.
- R9: A test whose mask imm is 0 always requests a skip, for both polarities.
- R10: An operation that reads and writes the same location uses the value held before that cycle. The very next operation sees the updated value.
- R11: After reset, wb_valid, wb_to_mem, skip and carry are 0, and every register and memory cell reads 0.
- R12: A cycle with op_valid=0, or with code 0, changes no state. The next cycle shows wb_valid=0 and skip=0, and wb_data holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Decoded operation code (see requirements) |
| row | input | 2 | Memory row of all memory operands |
| col | input | 4 | Primary memory column |
| col_src | input | 4 | Source column of the same-row copy |
| reg_sel | input | 4 | Working register index |
| imm | input | 4 | Immediate value or test mask |
| wb_valid | output | 1 | A result was written by the previous operation |
| wb_to_mem | output | 1 | That result went to memory rather than a register |
| wb_data | output | 4 | Value written by the previous operation |
| carry | output | 1 | Carry flag |
| skip | output | 1 | Skip request from the previous test |

## Verification
The bench sweeps every pair of register and memory values through the register logic forms, and every memory/immediate pair through the immediate forms. A design that wrote the wrong target, or swapped the operand order of an immediate form, would report the wrong flag or the wrong data. Tests run over all values and masks, including the zero mask. A design that compared against "any bit" instead of "all bits", or that did not skip on an empty mask, would miscompare there. Indirect moves run with every register value as the column, and rotates are chained across carry. Together these catch a column taken from the instruction instead of the register, and a carry that logic operations disturb. Repeated read-modify-write of one cell in back-to-back cycles exposes a design that forwards, or that reads stale data one cycle too late.

// File: rtl/nib_pkg.sv
package nib_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_ANDR  = 4'd1,
    OP_ANDI  = 4'd2,
    OP_ORR   = 4'd3,
    OP_ORI   = 4'd4,
    OP_XORR  = 4'd5,
    OP_XORI  = 4'd6,
    OP_ROTR  = 4'd7,
    OP_LOAD  = 4'd8,
    OP_STORE = 4'd9,
    OP_MVIND = 4'd10,
    OP_MVFRI = 4'd11,
    OP_MVCOL = 4'd12,
    OP_MVIMM = 4'd13,
    OP_TALL1 = 4'd14,
    OP_TALL0 = 4'd15
  } nib_op_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_REG  = 2'd1,
    DST_MEM  = 2'd2
  } nib_dst_e;

endpackage

// File: rtl/nib_store.sv
module nib_store #(
  parameter int DW  = 4,
  parameter int AW  = 4,
  parameter int NRD = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][DW-1:0]   rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells_q [DEPTH];
  logic [DW-1:0] cells_d [DEPTH];

  // next state: a single write port, all other cells hold
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      cells_d[i] = cells_q[i];
    end
    if (we) begin
      cells_d[waddr] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        cells_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        cells_q[i] <= cells_d[i];
      end
    end
  end

  // reads see the contents held before this cycle's write
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = cells_q[raddr[p]];
  end

  // R10
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cells_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nib_pkg::*;
#(
  parameter int DW = 4
) (
  input  nib_op_e        op,
  input  logic [DW-1:0]  reg_v,
  input  logic [DW-1:0]  mem_a,
  input  logic [DW-1:0]  mem_b,
  input  logic [DW-1:0]  imm,
  input  logic           cin,
  output logic [DW-1:0]  res,
  output nib_dst_e       dst,
  output logic           cout,
  output logic           skip_o
);

  logic [DW-1:0] sel_bits;
  logic          all_one;
  logic          all_zero;

  assign sel_bits = mem_a & imm;
  assign all_one  = (sel_bits == imm);
  assign all_zero = (sel_bits == '0);

  always_comb begin
    res    = '0;
    dst    = DST_NONE;
    cout   = cin;
    skip_o = 1'b0;
    unique case (op)
      OP_ANDR:  begin res = reg_v & mem_a; dst = DST_REG; end
      OP_ORR:   begin res = reg_v | mem_a; dst = DST_REG; end
      OP_XORR:  begin res = reg_v ^ mem_a; dst = DST_REG; end
      OP_ANDI:  begin res = mem_a & imm;   dst = DST_MEM; end
      OP_ORI:   begin res = mem_a | imm;   dst = DST_MEM; end
      OP_XORI:  begin res = mem_a ^ imm;   dst = DST_MEM; end
      OP_ROTR: begin
        res  = {cin, reg_v[DW-1:1]};
        cout = reg_v[0];
        dst  = DST_REG;
      end
      OP_LOAD:  begin res = mem_a; dst = DST_REG; end
      OP_STORE: begin res = reg_v; dst = DST_MEM; end
      OP_MVIND: begin res = mem_a; dst = DST_MEM; end
      OP_MVFRI: begin res = mem_b; dst = DST_MEM; end
      OP_MVCOL: begin res = mem_b; dst = DST_MEM; end
      OP_MVIMM: begin res = imm;   dst = DST_MEM; end
      OP_TALL1: skip_o = all_one;
      OP_TALL0: skip_o = all_zero;
      default:  ;
    endcase
  end

  // R9
  always_comb begin
    if ((op == OP_TALL1 || op == OP_TALL0) && imm == '0) begin
      mask_zero_chk: assert (skip_o);
    end
  end

endmodule

// File: rtl/nib_exec.sv
module nib_exec
  import nib_pkg::*;
#(
  parameter int DW   = 4,
  parameter int RW   = 2,
  parameter int CW   = 4,
  parameter int NREG = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       op_valid,
  input  logic [3:0]                 op_code,
  input  logic [RW-1:0]              row,
  input  logic [CW-1:0]              col,
  input  logic [CW-1:0]              col_src,
  input  logic [$clog2(NREG)-1:0]    reg_sel,
  input  logic [DW-1:0]              imm,
  output logic                       wb_valid,
  output logic                       wb_to_mem,
  output logic [DW-1:0]              wb_data,
  output logic                       carry,
  output logic                       skip
);

  localparam int RIW = $clog2(NREG);
  localparam int MAW = RW + CW;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  nib_op_e op;
  assign op = nib_op_e'(op_code);

  // register file
  logic [0:0][DW-1:0]  reg_rdata;
  logic [0:0][RIW-1:0] reg_raddr;
  logic [DW-1:0]       reg_rd;
  logic                reg_we;

  assign reg_raddr[0] = reg_sel;
  assign reg_rd       = reg_rdata[0];

  // column named by register contents
  logic [CW-1:0] ind_col;
  if (CW <= DW) begin : g_col_narrow
    assign ind_col = reg_rd[CW-1:0];
  end else begin : g_col_wide
    assign ind_col = {{(CW-DW){1'b0}}, reg_rd};
  end

  // data memory: port 0 primary operand, port 1 second column
  logic [1:0][MAW-1:0] mem_raddr;
  logic [1:0][DW-1:0]  mem_rdata;
  logic                mem_we;
  logic [MAW-1:0]      mem_waddr;
  logic [CW-1:0]       src_col;
  logic [CW-1:0]       dst_col;

  assign src_col      = (op == OP_MVFRI) ? ind_col : col_src;
  assign dst_col      = (op == OP_MVIND) ? ind_col : col;
  assign mem_raddr[0] = {row, col};
  assign mem_raddr[1] = {row, src_col};
  assign mem_waddr    = {row, dst_col};

  // execute
  logic [DW-1:0] alu_res;
  nib_dst_e      alu_dst;
  logic          alu_cout;
  logic          alu_skip;

  nib_alu #(.DW(DW)) u_alu (
    .op     (op),
    .reg_v  (reg_rd),
    .mem_a  (mem_rdata[0]),
    .mem_b  (mem_rdata[1]),
    .imm    (imm),
    .cin    (carry),
    .res    (alu_res),
    .dst    (alu_dst),
    .cout   (alu_cout),
    .skip_o (alu_skip)
  );

  assign reg_we = op_valid && (alu_dst == DST_REG);
  assign mem_we = op_valid && (alu_dst == DST_MEM);

  nib_store #(.DW(DW), .AW(RIW), .NRD(1)) u_regs (
    .clk   (clk),
    .rst_n (rst_q_n),
    .we    (reg_we),
    .waddr (reg_sel),
    .wdata (alu_res),
    .raddr (reg_raddr),
    .rdata (reg_rdata)
  );

  nib_store #(.DW(DW), .AW(MAW), .NRD(2)) u_mem (
    .clk   (clk),
    .rst_n (rst_q_n),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (alu_res),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  // result stage
  logic          wbv_d, wbm_d, cy_d, sk_d;
  logic [DW-1:0] wbd_d;
  logic          wbv_q, wbm_q, cy_q, sk_q;
  logic [DW-1:0] wbd_q;

  always_comb begin
    wbv_d = reg_we || mem_we;
    wbm_d = mem_we;
    sk_d  = op_valid && alu_skip;
    wbd_d = wbd_q;
    cy_d  = cy_q;
    if (reg_we || mem_we) wbd_d = alu_res;
    if (op_valid)         cy_d  = alu_cout;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      wbv_q <= 1'b0;
      wbm_q <= 1'b0;
      wbd_q <= '0;
      cy_q  <= 1'b0;
      sk_q  <= 1'b0;
    end else begin
      wbv_q <= wbv_d;
      wbm_q <= wbm_d;
      wbd_q <= wbd_d;
      cy_q  <= cy_d;
      sk_q  <= sk_d;
    end
  end

  assign wb_valid  = wbv_q;
  assign wb_to_mem = wbm_q;
  assign wb_data   = wbd_q;
  assign carry     = cy_q;
  assign skip      = sk_q;

  // R3
  rotate_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_valid && op == OP_ROTR) |=>
      (carry == $past(reg_rd[0]) &&
       wb_data == {$past(carry), $past(reg_rd[DW-1:1])}));

  // R4
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(op_valid && op == OP_ROTR) |=> $stable(carry));

  // R8
  skip_src_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(op_valid && (op == OP_TALL1 || op == OP_TALL0)) |=> !skip);

  // R8
  test_no_write_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (op_valid && (op == OP_TALL1 || op == OP_TALL0)) |=> !wb_valid);

  // R12
  idle_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !op_valid |=> (!wb_valid && !skip && $stable(wb_data)));

  // R2
  mem_flag_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    wb_to_mem |-> wb_valid);

endmodule

// File: tb/nib_exec_bench.sv
module nib_exec_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [3:0] op_code;
  logic [1:0] row;
  logic [3:0] col, col_src, reg_sel, imm;
  logic       wb_valid, wb_to_mem, carry, skip;
  logic [3:0] wb_data;

  always #10 clk = ~clk;

  nib_exec u_nib_exec (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .row(row), .col(col), .col_src(col_src), .reg_sel(reg_sel), .imm(imm),
    .wb_valid(wb_valid), .wb_to_mem(wb_to_mem), .wb_data(wb_data),
    .carry(carry), .skip(skip)
  );

  int vec_cnt = 0;
  int bad_cnt = 0;
  bit done = 0;

  int mem_m [64];
  int reg_m [16];
  int cy_m;
  int last_d;

  task automatic check(input string tag, input int ev, input int em, input int ed,
                       input int ec, input int es);
    vec_cnt++;
    if (wb_valid !== ev[0] || wb_to_mem !== em[0] || carry !== ec[0] ||
        skip !== es[0] || wb_data !== ed[3:0]) begin
      bad_cnt++;
      $display("FAIL %s: v/m/d/c/s actual %0d/%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d/%0d",
               tag, wb_valid, wb_to_mem, wb_data, carry, skip, ev, em, ed, ec, es);
    end
  endtask

  // one operation per cycle: drive at negedge, check at the next negedge
  task automatic apply(input int op, input int dh, input int dl, input int dl2,
                       input int r, input int iv, input string tag);
    int a, m, b, res, ev, em, es, wa;
    a = reg_m[r]; m = mem_m[dh*16 + dl];
    b = (op == 11) ? mem_m[dh*16 + a] : mem_m[dh*16 + dl2];
    ev = 1; em = 1; es = 0; res = 0; wa = dh*16 + dl;
    case (op)
      1: begin res = a & m; em = 0; end
      3: begin res = a | m; em = 0; end
      5: begin res = a ^ m; em = 0; end
      2: res = m & iv;
      4: res = m | iv;
      6: res = m ^ iv;
      7: begin res = (cy_m << 3) | (a >> 1); cy_m = a & 1; em = 0; end
      8: begin res = m; em = 0; end
      9: res = a;
      10: begin res = m; wa = dh*16 + a; end
      11: res = b;
      12: res = b;
      13: res = iv;
      14: begin ev = 0; em = 0; es = ((m & iv) == iv); end
      15: begin ev = 0; em = 0; es = ((m & iv) == 0); end
      default: begin ev = 0; em = 0; end
    endcase
    if (ev == 1) begin
      if (em == 1) mem_m[wa] = res; else reg_m[r] = res;
      last_d = res;
    end
    op_valid = 1'b1; op_code = op[3:0]; row = dh[1:0]; col = dl[3:0];
    col_src = dl2[3:0]; reg_sel = r[3:0]; imm = iv[3:0];
    @(posedge clk); @(negedge clk);
    check(tag, ev, em, last_d, cy_m, es);
  endtask

  task automatic idle(input string tag);
    op_valid = 1'b0; op_code = 4'd13;
    @(posedge clk); @(negedge clk);
    check(tag, 0, 0, last_d, cy_m, 0);
  endtask

  task automatic set_reg(input int r, input int v);
    apply(13, 3, 15, 0, 0, v, "R5");
    apply(8, 3, 15, 0, r, 0, "R5");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem_m[i] = 0;
    for (int i = 0; i < 16; i++) reg_m[i] = 0;
    cy_m = 0; last_d = 0;
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; row = '0; col = '0;
    col_src = '0; reg_sel = '0; imm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11", 0, 0, 0, 0, 0);
    // R11: everything reads zero after reset
    for (int r = 0; r < 16; r++) apply(8, r % 4, r, 0, r, 0, "R11");
    for (int i = 0; i < 64; i++) apply(14, i / 16, i % 16, 0, 0, 15, "R11");
    // R5: immediate writes, loads, stores
    for (int i = 0; i < 64; i++) apply(13, i / 16, i % 16, 0, 0, (i * 7 + 3) % 16, "R5");
    for (int r = 0; r < 16; r++) apply(8, 1, r, 0, r, 0, "R5");
    for (int r = 0; r < 16; r++) apply(9, 2, 15 - r, 0, r, 0, "R5");
    // R1: register logic forms, all operand pairs
    for (int a = 0; a < 16; a++)
      for (int m = 0; m < 16; m++)
        for (int k = 0; k < 3; k++) begin
          set_reg(5, a);
          apply(13, 2, 9, 0, 0, m, "R5");
          apply(1 + 2 * k, 2, 9, 0, 5, 0, "R1");
        end
    // R2 and R10: immediate forms, then back-to-back on the same cell
    for (int m = 0; m < 16; m++)
      for (int v = 0; v < 16; v++)
        for (int k = 0; k < 3; k++) begin
          apply(13, 1, 4, 0, 0, m, "R5");
          apply(2 + 2 * k, 1, 4, 0, 0, v, "R2");
          apply(6, 1, 4, 0, 0, 5, "R10");
        end
    // R3, R4: rotate chains across the carry, logic in between
    for (int a = 0; a < 16; a++) begin
      set_reg(7, a);
      for (int s = 0; s < 5; s++) apply(7, 0, 0, 0, 7, 0, "R3");
      apply(5, 0, 3, 0, 7, 0, "R4");
      apply(6, 0, 3, 0, 0, 15, "R4");
      idle("R12");
    end
    // R6: same-row copy, all column pairs in one row
    for (int d = 0; d < 16; d++)
      for (int s = 0; s < 16; s++) begin
        apply(13, 2, s, 0, 0, (d + s * 3) % 16, "R5");
        apply(12, 2, d, s, 0, 0, "R6");
        apply(8, 1, d, 0, 1, 0, "R6");
        apply(8, 2, d, 0, 2, 0, "R6");
      end
    // R7: indirect moves with every register value as the column
    for (int c = 0; c < 16; c++) begin
      set_reg(9, c);
      apply(13, 3, 2, 0, 0, 15 - c, "R5");
      apply(10, 3, 2, 0, 9, 0, "R7");
      apply(8, 3, c, 0, 4, 0, "R7");
      apply(13, 0, c, 0, 0, c ^ 6, "R5");
      apply(11, 0, 1, 0, 9, 0, "R7");
      apply(8, 0, 1, 0, 4, 0, "R7");
    end
    // R8, R9: tests over all values and masks
    for (int m = 0; m < 16; m++)
      for (int n = 0; n < 16; n++) begin
        apply(13, 1, 8, 0, 0, m, "R5");
        apply(14, 1, 8, 0, 0, n, (n == 0) ? "R9" : "R8");
        apply(15, 1, 8, 0, 0, n, (n == 0) ? "R9" : "R8");
        if (n % 5 == 0) idle("R12");
      end
    // R12: no-operation code
    apply(0, 0, 0, 0, 0, 9, "R12");
    // R10: mixed sequence
    for (int i = 0; i < 3000; i++) begin
      int o;
      o = $urandom_range(15);
      apply(o, $urandom_range(3), $urandom_range(15), $urandom_range(15),
            $urandom_range(15), $urandom_range(15), "R10");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad_cnt++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
    end
  end

endmodule